// File: doc/BRIEF.md
# Prescaled Eight-Bit Timer

An 8-bit up-counter that counts one of two sources: an internal instruction-cycle tick, which is the system clock divided by a fixed ratio, or an external pin. The external pin is synchronised inside the block, and either its rising or its falling edge can be chosen as the counting edge. When the counter rolls over from 0xFF to 0x00 it sets a sticky overflow flag, which software clears.

A single 8-bit prescaler sits between the source and the counter, or it can be handed to a separate watchdog. When the watchdog owns it, the prescaler divides the watchdog's raw tick, its divided output goes out on a tap, and the timer counts every source tick. Software reloads the count through a write port. While the timer owns the prescaler, that write also restarts the prescaler.

Top module: `pscl_timer8`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0 and every control bit is 1. The timer then counts falling edges of the external pin at 1:1, and the watchdog tap runs at 1:128.
- R2: With control bit 5 = 0 the timer counts the internal tick, which occurs once every CYC_DIV (default 4) clocks. With 1:1 counting, any 400 consecutive clocks after a count write give exactly 100 increments.
- R3: With control bit 5 = 1 the external pin is the source, seen through a two-flop synchroniser. Control bit 4 = 1 counts high-to-low edges and bit 4 = 0 counts low-to-high edges. Each edge gives at most one tick, and the opposite edge has no effect.
- R4: With control bit 3 = 0 the prescaler serves the timer. The rate code in bits 2:0 (value n, 0 to 7) gives one count increment per 2^(n+1) source ticks, measured from a count write.
- R5: With control bit 3 = 1 the timer counts every source tick, and wdt_tap_o pulses once per 2^n pulses of wdt_tick_i (1:1 to 1:128). With bit 3 = 0, wdt_tap_o stays 0.
- R6: A rollover from 0xFF to 0x00 sets ovf_o, which stays set until ovf_clr_i. A rollover in the same cycle as a clear leaves the flag set.
- R7: A count write loads cnt_wdata_i on the next clock. It takes priority over an increment in the same cycle, and that cycle produces no overflow.
- R8: A count write clears the prescaler when bit 3 = 0. When bit 3 = 1, the watchdog's prescaler phase is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_i | input | 6 | Control word: [5] source, [4] edge, [3] assignment, [2:0] rate |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 8 | Count write data |
| cnt_o | output | 8 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Overflow flag clear |
| ext_pin_i | input | 1 | External count source (asynchronous) |
| wdt_tick_i | input | 1 | Raw watchdog tick, one clock wide |
| wdt_tap_o | output | 1 | Prescaled tick to the watchdog |

## Verification
The bench sweeps all eight rate codes in timer mode using counted external edges. An off-by-one in the tap mask would shift the count by a factor of two, and a prescaler that kept running through a count write would show up as an early increment. All eight watchdog ratios are checked over whole periods: a design that reused the timer ratios would emit half as many taps. A single edge checks that the opposite edge is ignored, and a design that detected edges on the raw pin or on level would count twice or never. A rollover and a write are placed on the exact increment cycle, and so are a rollover and a flag clear, to check that the write wins and the set wins.

// File: rtl/pscl_timer8_pkg.sv
package pscl_timer8_pkg;
  localparam int RATE_W = 3;
  localparam int PS_W   = 2 ** RATE_W;

  typedef struct packed {
    logic              src_ext;
    logic              edge_fall;
    logic              ps_wdt;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pscl_timer8_cyc_div.sv
module pscl_timer8_cyc_div #(
  parameter int CYC_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CYC_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + DW'(1);
  end

  assign tick_o = (div_q == LAST);

  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CYC_DIV > 1 && tick_o) |=> !tick_o);
endmodule

// File: rtl/pscl_timer8_edge_sync.sv
module pscl_timer8_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic tick_o
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise   = s2_q & ~s3_q;
  assign fall   = ~s2_q & s3_q;
  assign tick_o = fall_sel_i ? fall : rise;

  assert_one_tick_per_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_edge_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise, fall}));
endmodule

// File: rtl/pscl_timer8_prescaler.sv
module pscl_timer8_prescaler
  import pscl_timer8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic              wdt_mode_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tap_o
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;

  // timer taps 2^(n+1), watchdog taps 2^n
  always_comb begin
    for (int i = 0; i < PS_W; i++) begin
      mask[i] = wdt_mode_i ? (i < int'(rate_i)) : (i <= int'(rate_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ps_q <= '0;
    else if (clr_i)  ps_q <= '0;
    else if (tick_i) ps_q <= ps_q + PS_W'(1);
  end

  assign tap_o = tick_i & ((ps_q & mask) == mask);

  assert_clear_restarts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ps_q == '0));
endmodule

// File: rtl/pscl_timer8.sv
module pscl_timer8
  import pscl_timer8_pkg::*;
#(
  parameter int CYC_DIV = 4,
  parameter int CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i,
  input  logic              ext_pin_i,
  input  logic              wdt_tick_i,
  output logic              wdt_tap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctrl_t ctrl_q;
  logic  cyc_tick, ext_tick, src_tick;
  logic  ps_in, ps_tap, ps_clr, cnt_inc;
  logic [CNT_W-1:0] cnt_q;
  logic  ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '1;
    else if (ctrl_we_i) ctrl_q <= ctrl_t'(ctrl_i);
  end

  pscl_timer8_cyc_div #(.CYC_DIV(CYC_DIV)) i_cyc_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (cyc_tick)
  );

  pscl_timer8_edge_sync i_edge_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .fall_sel_i (ctrl_q.edge_fall),
    .tick_o     (ext_tick)
  );

  assign src_tick = ctrl_q.src_ext ? ext_tick : cyc_tick;
  assign ps_in    = ctrl_q.ps_wdt ? wdt_tick_i : src_tick;
  assign ps_clr   = cnt_we_i & ~ctrl_q.ps_wdt;

  pscl_timer8_prescaler i_prescaler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (ps_in),
    .clr_i      (ps_clr),
    .wdt_mode_i (ctrl_q.ps_wdt),
    .rate_i     (ctrl_q.rate),
    .tap_o      (ps_tap)
  );

  assign cnt_inc   = ctrl_q.ps_wdt ? src_tick : ps_tap;
  assign wdt_tap_o = ctrl_q.ps_wdt & ps_tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_wdata_i;
    else if (cnt_inc)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // a rollover beats a clear; a write suppresses the rollover
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      ovf_q <= 1'b0;
    else if (cnt_inc && !cnt_we_i && cnt_q == CNT_MAX) ovf_q <= 1'b1;
    else if (ovf_clr_i)                               ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_write_loads_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_o == $past(cnt_wdata_i)));
  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1)));
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  assert_ovf_on_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($past(cnt_o) == CNT_MAX && cnt_o == '0));
  assert_wdt_tap_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.ps_wdt |-> !wdt_tap_o);
endmodule

// File: tb/test_pscl_timer8.sv
module test_pscl_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [5:0] ctrl = 6'h00;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = 8'h00;
  logic [7:0] cnt;
  logic       ovf;
  logic       ovf_clr = 1'b0;
  logic       pin = 1'b0;
  logic       wdt_tick = 1'b0;
  logic       wdt_tap;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pscl_timer8 i_pscl_timer8 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctrl_we_i   (ctrl_we),
    .ctrl_i      (ctrl),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (cnt_wdata),
    .cnt_o       (cnt),
    .ovf_o       (ovf),
    .ovf_clr_i   (ovf_clr),
    .ext_pin_i   (pin),
    .wdt_tick_i  (wdt_tick),
    .wdt_tap_o   (wdt_tap)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input bit src, input bit fall, input bit wdt, input int rate);
    @(negedge clk);
    ctrl = {src, fall, wdt, 3'(rate)};
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic write_cnt(input logic [7:0] v);
    @(negedge clk);
    cnt_wdata = v;
    cnt_we = 1'b1;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); pin = 1'b1;
      repeat (3) @(negedge clk);
      pin = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wdt_pulses(input int k, output int taps);
    taps = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk); wdt_tick = 1'b1;
      #1 if (wdt_tap) taps++;
      @(negedge clk); wdt_tick = 1'b0;
    end
  endtask

  // pin rises at a negedge; its increment lands on the third posedge
  task automatic edge_with(input bit do_clr, input bit do_wr, input logic [7:0] v);
    @(negedge clk); pin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    ovf_clr = do_clr; cnt_we = do_wr; cnt_wdata = v;
    @(negedge clk);
    ovf_clr = 1'b0; cnt_we = 1'b0;
    pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int taps;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and defaults
    check("R1 count", cnt, 0);
    check("R1 ovf", ovf, 0);
    check("R1 tap", wdt_tap, 0);
    @(negedge clk); pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 rise ignored by default", cnt, 0);
    pin = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 default falling 1:1", cnt, 1);

    // R3 edge select
    set_ctrl(1, 1, 1, 0);
    write_cnt(8'h10);
    @(negedge clk); pin = 1'b1; repeat (5) @(negedge clk);
    check("R3 fall mode ignores rise", cnt, 16);
    pin = 1'b0; repeat (5) @(negedge clk);
    check("R3 fall mode counts fall", cnt, 17);
    set_ctrl(1, 0, 1, 0);
    write_cnt(8'h20);
    @(negedge clk); pin = 1'b1; repeat (5) @(negedge clk);
    check("R3 rise mode counts rise", cnt, 33);
    pin = 1'b0; repeat (5) @(negedge clk);
    check("R3 rise mode ignores fall", cnt, 33);
    pulses(7);
    check("R3 one tick per edge", cnt, 40);

    // R2 internal source, 1:1 and 1:2
    set_ctrl(0, 0, 1, 0);
    write_cnt(8'h00);
    repeat (400) @(posedge clk);
    @(negedge clk);
    check("R2 internal 1:1", cnt, 100);
    set_ctrl(0, 0, 0, 0);
    write_cnt(8'h00);
    repeat (800) @(posedge clk);
    @(negedge clk);
    check("R2 internal via 1:2", cnt, 100);

    // R4 all timer rates
    for (int n = 0; n < 8; n++) begin
      set_ctrl(1, 0, 0, n);
      write_cnt(8'h00);
      pulses(3 * (2 ** (n + 1)) - 1);
      check($sformatf("R4 rate %0d below step", n), cnt, 2);
      pulses(1);
      check($sformatf("R4 rate %0d at step", n), cnt, 3);
    end

    // R5 watchdog rates and gating
    for (int n = 0; n < 8; n++) begin
      set_ctrl(1, 0, 1, n);
      wdt_pulses(4 * (2 ** n), taps);
      check($sformatf("R5 wdt rate %0d taps", n), taps, 4);
    end
    set_ctrl(1, 0, 0, 0);
    wdt_pulses(8, taps);
    check("R5 tap quiet in timer mode", taps, 0);

    // R6 overflow
    set_ctrl(1, 0, 1, 0);
    write_cnt(8'hFF);
    pulses(1);
    check("R6 wrap count", cnt, 0);
    check("R6 wrap sets flag", ovf, 1);
    pulses(1);
    check("R6 flag sticky", ovf, 1);
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    check("R6 flag clears", ovf, 0);
    write_cnt(8'hFF);
    edge_with(1'b1, 1'b0, 8'h00);
    check("R6 set beats clear", ovf, 1);
    check("R6 set beats clear count", cnt, 0);

    // R7 write priority
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    write_cnt(8'hFF);
    edge_with(1'b0, 1'b1, 8'h40);
    check("R7 write beats increment", cnt, 64);
    check("R7 no overflow on write", ovf, 0);

    // R8 prescaler clear on write
    set_ctrl(1, 0, 0, 0);
    write_cnt(8'h00);
    pulses(1);
    check("R8 half way", cnt, 0);
    write_cnt(8'h00);
    pulses(1);
    check("R8 write restarted prescaler", cnt, 0);
    pulses(1);
    check("R8 step after restart", cnt, 1);
    set_ctrl(1, 0, 0, 1);
    write_cnt(8'h00);
    set_ctrl(1, 0, 1, 1);
    wdt_pulses(1, taps);
    check("R8 wdt first tick", taps, 0);
    write_cnt(8'h05);
    wdt_pulses(1, taps);
    check("R8 wdt phase kept over write", taps, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule